// File: doc/BRIEF.md
# Voice Memory Row Sequencer

This block paces record and playback through a sample memory organised in rows. Every row is split into eight equal segments. Outside cueing, the row position moves forward one step per sample-rate tick. The block drives the current row address toward the sample store, together with an active-low row strobe that goes low during the final eighth of each row. That gives the strobe a 7:1 high/low duty cycle.

A message-cueing variant of playback moves forward one whole segment per system clock, which keeps the 7:1 shape at a much faster row rate. A record that starts from idle holds the strobe high for an extra preload interval before row timing begins.

The sequencer halts and holds its row address in two cases: when it runs past the last row (overflow), or, during playback only, when it reaches a segment whose end-of-message marker bit is set. Each halt sets a sticky flag and pulls the active-low interrupt output low. The flags clear when the next serial-interface cycle begins, and a read-interrupt request copies both flags onto status outputs. All outputs are registered logic levels, ready for an open-drain pad.

Top module: `vm_row_seq`

## Requirements
- R1: While `rst` is high, at the next clock edge `row_addr` becomes 0, `row_stb_n` and `int_n` become 1, and `stat_ovf` and `stat_eom` become 0.
- R2: In a normal (non-cueing) run, one row spans 8*SEG_TICKS sample ticks and the position moves only on clocks where `smp_tick` is 1. `row_stb_n` is 0 exactly while the position is in segment 7, the last segment of the row, and is 1 otherwise. `row_addr` increments when a row completes.
- R3: When the last row (ROWS-1) completes, during record or playback, the overflow flag is set and the sequencer halts. `row_addr` holds at ROWS-1, `row_stb_n` returns to 1 and `int_n` goes to 0, all at the same edge.
- R4: During playback only, at the end of segment s (0 = first segment), the sequencer halts when bit s of `eom_map` is set. The end-of-message flag is set, `row_addr` holds and `int_n` goes to 0. A record run ignores `eom_map`. The end-of-message check comes before the row-complete check.
- R5: A playback started with `cue_mode` = 1 moves forward one segment per clock whatever `smp_tick` does. The row therefore lasts 8 clocks, with `row_stb_n` low on the 8th.
- R6: A record started from idle holds `row_stb_n` high for PRELOAD_TICKS extra ticks before segment 0 begins. A record started from the halted state starts row timing at once.
- R7: A `spi_start` pulse clears both flags, so `int_n` is 1 after the edge. If a flag is set in the same cycle, the set wins.
- R8: A `rd_int` pulse copies the overflow and end-of-message flags, as they stood before that edge, to `stat_ovf` and `stat_eom`, which then hold.
- R9: A new command after an overflow halt restarts at row 0. After an end-of-message halt, or from idle, it keeps the current row and starts at segment 0.
- R10: `stop_req` during preload or run returns the block to idle with `row_stb_n` = 1 and `row_addr` held. Start commands that arrive while running are ignored, and ticks in idle move nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | Sample-rate tick, one clock wide |
| play_go | input | 1 | Start playback (accepted in idle or halted) |
| rec_go | input | 1 | Start record (has priority over play_go) |
| cue_mode | input | 1 | Sampled with play_go: selects message-cueing pace |
| stop_req | input | 1 | Stop the current operation |
| eom_map | input | 8 | End-of-message marker bits of the current row, bit s = segment s |
| spi_start | input | 1 | Serial cycle start pulse, clears the flags |
| rd_int | input | 1 | Read-interrupt request |
| row_addr | output | ROW_W | Current row address |
| row_stb_n | output | 1 | Active-low row-end strobe |
| int_n | output | 1 | Active-low interrupt |
| stat_ovf | output | 1 | Overflow status captured by rd_int |
| stat_eom | output | 1 | End-of-message status captured by rd_int |

## Verification
The assertions assume that the command inputs are single-clock pulses and that `eom_map` always describes the row on `row_addr`. The stimulus applies every input at the falling edge and holds it for one clock only, and it changes `eom_map` only between rows. The row-step assertion also relies on the address moving forward at most one row per clock, or wrapping to zero. The stimulus respects this by never pulsing a start command together with a row completion.

// File: rtl/vmr_pkg.sv
package vmr_pkg;
  localparam int SEGS = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_HALT} vmr_state_e;
endpackage

// File: rtl/vmr_timer.sv
module vmr_timer
  import vmr_pkg::*;
#(
  parameter int ROWS          = 2400,
  parameter int SEG_TICKS     = 200,
  parameter int PRELOAD_TICKS = 400
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    go_play,
  input  logic                    go_rec,
  input  logic                    cue,
  input  logic                    stop,
  input  logic [SEGS-1:0]         eom_map,
  output logic [$clog2(ROWS)-1:0] row_addr,
  output logic                    row_stb_n,
  output logic                    busy,
  output logic                    ovf_evt,
  output logic                    eom_evt
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int SUB_W = $clog2(SEG_TICKS);
  localparam int PRE_W = $clog2(PRELOAD_TICKS + 2);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SEG_TICKS - 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRELOAD_TICKS - 1);

  vmr_state_e       state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [2:0]       seg_q, seg_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             rec_q, rec_d, cue_q, cue_d, wrap_q, wrap_d;
  logic             stb_q, adv, seg_end;

  always_comb begin
    state_d = state_q; row_d = row_q; seg_d = seg_q; sub_d = sub_q;
    pre_d = pre_q; rec_d = rec_q; cue_d = cue_q; wrap_d = wrap_q;
    ovf_evt = 1'b0; eom_evt = 1'b0; adv = 1'b0; seg_end = 1'b0;
    case (state_q)
      ST_IDLE, ST_HALT: begin
        if (go_play || go_rec) begin
          if (wrap_q) row_d = '0;
          wrap_d = 1'b0;
          seg_d  = '0;
          sub_d  = '0;
          pre_d  = '0;
          rec_d  = go_rec;
          cue_d  = cue && !go_rec;
          state_d = (go_rec && state_q == ST_IDLE && PRELOAD_TICKS > 0) ? ST_LOAD : ST_RUN;
        end
      end
      ST_LOAD: begin
        if (stop) state_d = ST_IDLE;
        else if (tick) begin
          if (pre_q == PRE_LAST) state_d = ST_RUN;
          else pre_d = pre_q + PRE_W'(1);
        end
      end
      ST_RUN: begin
        if (stop) state_d = ST_IDLE;
        else begin
          adv     = cue_q || tick;
          seg_end = cue_q || (sub_q == SUB_LAST);
          if (adv) begin
            if (!seg_end) sub_d = sub_q + SUB_W'(1);
            else begin
              sub_d = '0;
              if (!rec_q && eom_map[seg_q]) begin
                eom_evt = 1'b1;
                state_d = ST_HALT;
              end else if (seg_q == 3'd7) begin
                if (row_q == ROW_LAST) begin
                  ovf_evt = 1'b1;
                  wrap_d  = 1'b1;
                  state_d = ST_HALT;
                end else begin
                  row_d = row_q + ROW_W'(1);
                  seg_d = '0;
                end
              end else seg_d = seg_q + 3'd1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      seg_q   <= '0;
      sub_q   <= '0;
      pre_q   <= '0;
      rec_q   <= 1'b0;
      cue_q   <= 1'b0;
      wrap_q  <= 1'b0;
      stb_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      seg_q   <= seg_d;
      sub_q   <= sub_d;
      pre_q   <= pre_d;
      rec_q   <= rec_d;
      cue_q   <= cue_d;
      wrap_q  <= wrap_d;
      stb_q   <= !(state_d == ST_RUN && seg_d == 3'd7);
    end
  end

  assign row_addr  = row_q;
  assign row_stb_n = stb_q;
  assign busy      = (state_q == ST_LOAD) || (state_q == ST_RUN);
endmodule

// File: rtl/vmr_irq.sv
module vmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_ovf,
  input  logic set_eom,
  input  logic spi_start,
  input  logic rd_int,
  output logic ovf_flag,
  output logic eom_flag,
  output logic int_n,
  output logic stat_ovf,
  output logic stat_eom
);
  logic ovf_d, eom_d;

  always_comb begin
    ovf_d = set_ovf || (ovf_flag && !spi_start);
    eom_d = set_eom || (eom_flag && !spi_start);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      eom_flag <= 1'b0;
      int_n    <= 1'b1;
      stat_ovf <= 1'b0;
      stat_eom <= 1'b0;
    end else begin
      ovf_flag <= ovf_d;
      eom_flag <= eom_d;
      int_n    <= !(ovf_d || eom_d);
      if (rd_int) begin
        stat_ovf <= ovf_flag;
        stat_eom <= eom_flag;
      end
    end
  end
endmodule

// File: rtl/vm_row_seq.sv
module vm_row_seq #(
  parameter int ROWS          = 2400,
  parameter int SEG_TICKS     = 200,
  parameter int PRELOAD_TICKS = 400,
  localparam int ROW_W        = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_tick,
  input  logic             play_go,
  input  logic             rec_go,
  input  logic             cue_mode,
  input  logic             stop_req,
  input  logic [7:0]       eom_map,
  input  logic             spi_start,
  input  logic             rd_int,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_stb_n,
  output logic             int_n,
  output logic             stat_ovf,
  output logic             stat_eom
);
  logic busy, ovf_evt, eom_evt, ovf_flag, eom_flag, go;

  assign go = play_go || rec_go;

  vmr_timer #(
    .ROWS(ROWS), .SEG_TICKS(SEG_TICKS), .PRELOAD_TICKS(PRELOAD_TICKS)
  ) i_timer (
    .clk(clk), .rst(rst), .tick(smp_tick), .go_play(play_go), .go_rec(rec_go),
    .cue(cue_mode), .stop(stop_req), .eom_map(eom_map), .row_addr(row_addr),
    .row_stb_n(row_stb_n), .busy(busy), .ovf_evt(ovf_evt), .eom_evt(eom_evt)
  );

  vmr_irq i_irq (
    .clk(clk), .rst(rst), .set_ovf(ovf_evt), .set_eom(eom_evt),
    .spi_start(spi_start), .rd_int(rd_int), .ovf_flag(ovf_flag),
    .eom_flag(eom_flag), .int_n(int_n), .stat_ovf(stat_ovf), .stat_eom(stat_eom)
  );
endmodule

// File: rtl/vmr_chk.sv
module vmr_chk #(
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [ROW_W-1:0] row_addr,
  input logic             row_stb_n,
  input logic             int_n,
  input logic             busy,
  input logic             go,
  input logic             spi_start,
  input logic             rd_int,
  input logic             ovf_flag,
  input logic             eom_flag,
  input logic             stat_ovf,
  input logic             stat_eom
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (row_addr == '0 && row_stb_n && int_n && !stat_ovf && !stat_eom));

  a_r2_strobe_low_only_running: assert property (@(posedge clk) disable iff (rst)
    !row_stb_n |-> busy);

  a_r2_row_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (row_addr == $past(row_addr) || row_addr == $past(row_addr) + ROW_W'(1)
              || row_addr == '0));

  a_r7_clear_when_quiet: assert property (@(posedge clk) disable iff (rst)
    (spi_start && !busy) |=> int_n);

  a_r8_status_capture: assert property (@(posedge clk) disable iff (rst)
    rd_int |=> (stat_ovf == $past(ovf_flag) && stat_eom == $past(eom_flag)));

  a_r10_idle_row_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go) |=> $stable(row_addr));
endmodule

bind vm_row_seq vmr_chk #(.ROW_W(ROW_W)) i_chk (
  .clk(clk), .rst(rst), .row_addr(row_addr), .row_stb_n(row_stb_n), .int_n(int_n),
  .busy(busy), .go(go), .spi_start(spi_start), .rd_int(rd_int),
  .ovf_flag(ovf_flag), .eom_flag(eom_flag), .stat_ovf(stat_ovf), .stat_eom(stat_eom)
);

// File: tb/test_vm_row_seq.sv
`timescale 1ns/1ps
module test_vm_row_seq;
  localparam int ROWS = 4, SEG = 4, PRE = 6, RT = 8 * SEG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_tick = 0, play_go = 0, rec_go = 0, cue_mode = 0, stop_req = 0;
  logic spi_start = 0, rd_int = 0;
  logic [7:0] eom_map = '0;
  logic [1:0] row_addr;
  logic row_stb_n, int_n, stat_ovf, stat_eom;

  bit n_rst = 1'b1, n_cue = 1'b0;
  logic [7:0] n_map = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  int q_row[$];
  bit q_stb[$], q_int[$], q_chs[$], q_sov[$], q_seo[$];
  string q_req[$];

  always #2.5 clk = ~clk;

  vm_row_seq #(.ROWS(ROWS), .SEG_TICKS(SEG), .PRELOAD_TICKS(PRE)) i_vm_row_seq (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .play_go(play_go), .rec_go(rec_go),
    .cue_mode(cue_mode), .stop_req(stop_req), .eom_map(eom_map), .spi_start(spi_start),
    .rd_int(rd_int), .row_addr(row_addr), .row_stb_n(row_stb_n), .int_n(int_n),
    .stat_ovf(stat_ovf), .stat_eom(stat_eom)
  );

  task automatic step(input bit pl, rc, st, tk, sp, rd, input int erow,
                      input bit estb, eint, chs, eov, eeo, input string req);
    @(negedge clk);
    rst = n_rst; cue_mode = n_cue; eom_map = n_map;
    play_go = pl; rec_go = rc; stop_req = st; smp_tick = tk; spi_start = sp; rd_int = rd;
    q_row.push_back(erow); q_stb.push_back(estb); q_int.push_back(eint);
    q_chs.push_back(chs); q_sov.push_back(eov); q_seo.push_back(eeo); q_req.push_back(req);
  endtask

  task automatic idle(input int erow, input bit eint, input string req);
    step(0, 0, 0, 0, 0, 0, erow, 1'b1, eint, 1'b0, 1'b0, 1'b0, req);
  endtask

  // monitor: compares each pushed expectation one step after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_row.size() > 0) begin
        int erow;
        bit estb, eint, chs, eov, eeo;
        string req;
        erow = q_row.pop_front(); estb = q_stb.pop_front(); eint = q_int.pop_front();
        chs = q_chs.pop_front(); eov = q_sov.pop_front(); eeo = q_seo.pop_front();
        req = q_req.pop_front();
        checks++;
        if (int'(row_addr) != erow || row_stb_n != estb || int_n != eint ||
            (chs && (stat_ovf != eov || stat_eom != eeo))) begin
          fails++;
          $display("FAIL %s: row=%0d stb_n=%0b int_n=%0b st=%0b%0b expected row=%0d stb_n=%0b int_n=%0b st=%0b%0b",
                   req, row_addr, row_stb_n, int_n, stat_ovf, stat_eom,
                   erow, estb, eint, eov, eeo);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, c;
    bit tk;
    // R1 reset state
    n_rst = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R1");
    n_rst = 1'b0;

    // R2/R3 normal playback with tick gaps until overflow
    step(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R2");
    t = 0; c = 0;
    while (t < ROWS * RT) begin
      tk = (c % 5 != 4);
      c++;
      if (tk) t++;
      if (tk && t == ROWS * RT)
        step(0, 0, 0, 1, 0, 0, ROWS - 1, 1, 0, 0, 0, 0, "R3");
      else
        step(0, 0, 0, tk, 0, 0, t / RT, ((t % RT) / SEG) != 7, 1, 0, 0, 0, "R2");
    end
    idle(ROWS - 1, 0, "R3");
    step(0, 0, 0, 0, 0, 1, ROWS - 1, 1, 0, 1, 1, 0, "R8");
    step(0, 0, 0, 0, 1, 0, ROWS - 1, 1, 1, 1, 1, 0, "R7");

    // R5 cueing playback, restart at row 0 after overflow (R9)
    n_cue = 1'b1;
    step(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R9");
    for (int j = 1; j <= ROWS * 8; j++) begin
      if (j == ROWS * 8) step(0, 0, 0, 0, 0, 0, ROWS - 1, 1, 0, 0, 0, 0, "R3");
      else step(0, 0, 0, 0, 0, 0, j / 8, (j % 8) != 7, 1, 0, 0, 0, "R5");
    end
    n_cue = 1'b0;
    step(0, 0, 0, 0, 1, 0, ROWS - 1, 1, 1, 0, 0, 0, "R7");

    // R4 end-of-message at segment 1 of row 1
    step(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R9");
    for (int k = 1; k <= RT + 2 * SEG; k++) begin
      n_map = (k > RT) ? 8'h02 : 8'h00;
      if (k == RT + 2 * SEG) step(0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 0, 0, "R4");
      else step(0, 0, 0, 1, 0, 0, k / RT, ((k % RT) / SEG) != 7, 1, 0, 0, 0, "R4");
    end
    idle(1, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 0, 1, "R8");
    step(0, 0, 0, 0, 1, 0, 1, 1, 1, 1, 0, 1, "R7");

    // R6 record from halt: no preload, markers ignored, row kept (R9)
    n_map = 8'hFF;
    step(0, 1, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R9");
    for (int k = 1; k <= (ROWS - 1) * RT; k++) begin
      if (k == (ROWS - 1) * RT)
        step(0, 0, 0, 1, 1, 0, ROWS - 1, 1, 0, 0, 0, 0, "R7");
      else
        step(0, 0, 0, 1, 0, 0, 1 + k / RT, ((k % RT) / SEG) != 7, 1, 0, 0, 0, "R6");
    end
    n_map = 8'h00;
    step(0, 0, 0, 0, 1, 0, ROWS - 1, 1, 1, 0, 0, 0, "R7");

    // R10 ignored start while running, stop, idle ticks
    step(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R9");
    step(0, 1, 0, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R10");
    step(0, 0, 1, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R10");
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R10");

    // R6 record from idle: preload shifts row timing by PRE ticks
    step(0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R6");
    for (int k = 1; k <= PRE + RT + SEG + 3; k++) begin
      if (k <= PRE) step(0, 0, 0, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R6");
      else step(0, 0, 0, 1, 0, 0, (k - PRE) / RT, (((k - PRE) % RT) / SEG) != 7, 1, 0, 0, 0, "R6");
    end
    step(0, 0, 1, 1, 0, 0, 1, 1, 1, 0, 0, 0, "R10");
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 0, 1, 1, 1, 0, 0, 0, "R10");

    @(negedge clk);
    play_go = 0; rec_go = 0; stop_req = 0; smp_tick = 0; spi_start = 0; rd_int = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule